// File: doc/BRIEF.md
# Tick Timer with Mode and Count Registers

A 32-bit tick timer that sits behind a processor's special-register access port. Two registers control it: a mode word and a count word. The counter advances on every cycle in which the tick-enable input is high and the timer is running. The two-bit mode field selects how the counter behaves when its low bits reach the programmed period. It can stop, return to zero, hold after the first match, or keep counting. Each match latches a pending flag. The interrupt line is that flag gated by an enable bit.

Software uses the register port in three ways. It programs the mode word, loads or reads back the counter, and acknowledges interrupts. To acknowledge, it writes the mode word with the pending bit at 0. Writing the pending bit as 1 leaves the flag untouched, so the other fields can be rewritten without losing an interrupt that has not been serviced. Reads are combinational and always return the live count.

Top module: `tick_timer`

## Requirements
- R1: Register addresses are group * 2048 + number. With the default group of 10, the mode word is at 0x5000 and the count word is at 0x5001. Any other address reads as zero, and a write to it changes nothing.
- R2: The mode word has the mode in bits 31:30, interrupt enable in bit 29, pending in bit 28 and the period in bits 27:0. Mode encodings are 00 stopped, 01 restart, 10 one-shot and 11 continuous.
- R3: With mode 00 the counter holds its value. A mode write that changes the field from 00 to a running mode resumes counting from the value already held.
- R4: A mode-word write with bit 28 = 1 leaves the stored pending flag unchanged and loads every other field from the written data.
- R5: A mode-word write with bit 28 = 0 clears pending and drops the interrupt in the next cycle, unless a match occurs in that same cycle.
- R6: A match is a cycle in which the timer is running, tick-enable is high and count[27:0] equals the period. A match sets pending. The interrupt output is high exactly when pending and enable are both 1.
- R7: In restart mode (01) the counter goes to 0 on the edge that ends a match cycle.
- R8: In one-shot mode (10) the counter holds the matched value after a match. No further matches occur until the mode word or the count word is written.
- R9: In continuous mode (11) the counter keeps incrementing past a match and wraps from 0xFFFFFFFF to 0.
- R10: A count-word write loads the counter and takes priority over an increment or restart in the same cycle. A match in that same cycle still sets pending.
- R11: A read of the count word returns the current counter value without delay, one greater after each counting cycle.
- R12: After reset both registers read as zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Register address, shared by reads and writes |
| reg_wdata | input | 32 | Write data |
| tick_en | input | 1 | Count enable for this cycle |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| timer_irq | output | 1 | Timer interrupt request |

## Verification
On every cycle, the embedded assertions check these rules:
- the single-step increment;
- the hold while stopped or after a one-shot match;
- the return to zero in restart mode;
- the load priority of count writes;
- the keep-or-clear rule for the pending bit.

The scenarios that only the bench's runs can show are:
- whole count sequences;
- the exact tick on which a match lands for a given period;
- the 32-bit wrap in continuous mode;
- zero reads and ignored writes at unmapped addresses;
- resuming from a stopped count;
- re-arming a one-shot by a count write.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int ADDR_W    = 16,
  parameter int GROUP     = 10,
  parameter int GRP_SHIFT = 11,
  parameter int PERIOD_W  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              tick_en,
  output logic [31:0]       reg_rdata,
  output logic              timer_irq
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(GROUP << GRP_SHIFT);
  localparam logic [ADDR_W-1:0] CNT_ADDR  = ADDR_W'((GROUP << GRP_SHIFT) + 1);
  localparam logic [1:0] M_STOP = 2'b00, M_RESTART = 2'b01, M_ONESHOT = 2'b10;

  logic [1:0]          mode;
  logic                ie, pend, halted;
  logic [PERIOD_W-1:0] period;
  logic [31:0]         count;

  wire wr_mode = reg_wr && (reg_addr == MODE_ADDR);
  wire wr_cnt  = reg_wr && (reg_addr == CNT_ADDR);
  wire step    = (mode != M_STOP) && !halted && tick_en;
  wire hit     = step && (count[PERIOD_W-1:0] == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= M_STOP;
      ie     <= 1'b0;
      period <= '0;
    end else if (wr_mode) begin
      mode   <= reg_wdata[31:30];
      ie     <= reg_wdata[29];
      period <= reg_wdata[PERIOD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        pend <= 1'b0;
    else if (hit)                      pend <= 1'b1;
    else if (wr_mode && !reg_wdata[28]) pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        halted <= 1'b0;
    else if (wr_mode || wr_cnt)        halted <= 1'b0;
    else if (hit && mode == M_ONESHOT) halted <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        count <= '0;
    else if (wr_cnt)                   count <= reg_wdata;
    else if (hit && mode == M_RESTART) count <= '0;
    else if (hit && mode == M_ONESHOT) count <= count;
    else if (step)                     count <= count + 32'd1;
  end

  logic [31:0] mode_word;
  always_comb begin
    mode_word = '0;
    mode_word[31:30] = mode;
    mode_word[29] = ie;
    mode_word[28] = pend;
    mode_word[PERIOD_W-1:0] = period;
  end

  assign reg_rdata = (reg_addr == MODE_ADDR) ? mode_word :
                     (reg_addr == CNT_ADDR)  ? count : 32'd0;
  assign timer_irq = pend & ie;

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hit && !wr_cnt) |=> count == $past(count) + 32'd1);
  a_r3_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STOP && !wr_cnt) |=> $stable(count));
  a_r4_pend_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && reg_wdata[28] && !hit) |=> $stable(pend));
  a_r5_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !reg_wdata[28] && !hit) |=> !timer_irq);
  a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);
  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == M_RESTART && !wr_cnt) |=> count == 32'd0);
  a_r8_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_cnt) |=> $stable(count));
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(reg_wdata));
endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, tick_en = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic timer_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [15:0] A_MODE = 16'h5000, A_CNT = 16'h5001;

  tick_timer u_tick_timer (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tick_en(tick_en), .reg_rdata(reg_rdata), .timer_irq(timer_irq));

  always #5 clk = ~clk;

  // {mode word, preload, ticks, expected count, expected pending}
  localparam logic [112:0] VEC [8] = '{
    {32'h6000_0005, 32'h0000_0000, 16'd3,  32'h0000_0003, 1'b0},
    {32'h6000_0005, 32'h0000_0000, 16'd6,  32'h0000_0000, 1'b1},
    {32'h6000_0005, 32'h0000_0000, 16'd8,  32'h0000_0002, 1'b1},
    {32'h8000_0004, 32'h0000_0000, 16'd10, 32'h0000_0004, 1'b1},
    {32'hE000_0004, 32'h0000_0000, 16'd7,  32'h0000_0007, 1'b1},
    {32'h2000_0004, 32'h0000_0009, 16'd5,  32'h0000_0009, 1'b0},
    {32'hC000_0003, 32'hFFFF_FFFE, 16'd3,  32'h0000_0001, 1'b0},
    {32'h6000_0000, 32'h0000_0000, 16'd3,  32'h0000_0000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rd(A_MODE, v); chk("R12 mode reset", v, 32'h0);
    rd(A_CNT, v);  chk("R12 count reset", v, 32'h0);
    chk("R12 irq reset", {31'd0, timer_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = VEC[i][112:81];
      wr(A_CNT, VEC[i][80:49]);
      wr(A_MODE, w);
      ticks(int'(VEC[i][48:33]));
      rd(A_CNT, v);  chk($sformatf("R2/R7/R8/R9 vec%0d count", i), v, VEC[i][32:1]);
      rd(A_MODE, v); chk($sformatf("R6 vec%0d mode word", i), v, w | {3'd0, VEC[i][0], 28'd0});
      chk($sformatf("R6 vec%0d irq", i), {31'd0, timer_irq}, {31'd0, VEC[i][0] & w[29]});
    end

    // R4: pending kept when written as 1, other fields updated
    wr(A_MODE, 32'h7000_0007);
    rd(A_MODE, v); chk("R4 keep set pending", v, 32'h7000_0007);
    chk("R4 irq still high", {31'd0, timer_irq}, 32'd1);
    // R5: writing 0 clears
    wr(A_MODE, 32'h6000_0007);
    rd(A_MODE, v); chk("R5 clear pending", v, 32'h6000_0007);
    chk("R5 irq dropped", {31'd0, timer_irq}, 32'd0);
    wr(A_MODE, 32'h7000_0007);
    rd(A_MODE, v); chk("R4 keep clear pending", v, 32'h6000_0007);

    // R1: unmapped address
    wr(16'h5002, 32'hFFFF_FFFF);
    rd(A_MODE, v); chk("R1 mode untouched", v, 32'h6000_0007);
    rd(A_CNT, v);  chk("R1 count untouched", v, 32'h0);
    rd(16'h5002, v); chk("R1 unmapped read", v, 32'h0);
    rd(16'h2801, v); chk("R1 other group read", v, 32'h0);

    // R10: count write in a match cycle
    wr(A_MODE, 32'h6000_0002);
    wr(A_CNT, 32'h2);
    tick_en = 1'b1;
    wr(A_CNT, 32'h100);
    tick_en = 1'b0;
    rd(A_CNT, v);  chk("R10 load beats restart", v, 32'h100);
    rd(A_MODE, v); chk("R10 match still sets pending", v, 32'h7000_0002);

    // R3: stopped then resumed; R11 live reads
    wr(A_MODE, 32'h0000_0000);
    wr(A_CNT, 32'h7);
    ticks(3);
    rd(A_CNT, v); chk("R3 stopped holds", v, 32'h7);
    wr(A_MODE, 32'hC000_0FFF);
    tick_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rd(A_CNT, v); chk($sformatf("R11 live count %0d", k), v, 32'h7 + 32'(k));
      @(posedge clk); @(negedge clk);
    end
    tick_en = 1'b0;
    rd(A_CNT, v); chk("R3 resumed from held value", v, 32'hB);

    // R8: one-shot re-armed by count write
    wr(A_CNT, 32'h0);
    wr(A_MODE, 32'h8000_0003);
    ticks(6);
    rd(A_CNT, v); chk("R8 one-shot holds", v, 32'h3);
    wr(A_CNT, 32'h1);
    ticks(1);
    rd(A_CNT, v); chk("R8 re-armed after count write", v, 32'h2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule